// File: doc/BRIEF.md
# Packet Memory Pointer Access Port

This block lets a host reach a paged packet buffer through two small registers instead of a wide address bus. The host first loads a pointer word that holds a byte offset inside a packet plus three mode bits. It then moves data through a data port, either as 16-bit words or as single bytes. The packet whose page is accessed is chosen indirectly. It is either the packet at the head of the receive queue, which arrives on an input, or the packet number that the host wrote into a separate register.

The RAM address is the page base of the selected packet plus the pointer offset. The block keeps a read value prefetched at the current address, so the host reads without waiting for an address phase. A valid flag tells the host when the prefetched word matches the current address. With auto-increment enabled, each data access moves the offset forward, which lets the host stream a whole frame out or in. Inside a page, word 0 holds a status word, word 1 holds the byte count (11 significant bits), and the frame bytes follow. The last word carries a control byte in which bit 5 flags an odd length and bit 4 asks for CRC append on transmit. The port moves these bytes like any others and does not interpret them.

Top module: `pkt_ptr_port`

## Requirements
- R1: While reset is high, rd_valid and rd_word are 0. Reset also clears the pointer and packet-number registers.
- R2: Pointer bit 15 picks the packet. When it is 1 the packet is rxq_head. When it is 0 the packet is the value last written to the packet-number register (bus_sel = 1). While bit 15 is 1, a change of rxq_head changes the word that is read.
- R3: The word address is pkt * 2^(OFF_W-1) + offset[OFF_W-1:1], where the offset is pointer bits [OFF_W-1:0]. A word access at an odd offset ignores offset bit 0.
- R4: Pointer bit 14 enables auto-increment. When it is 1, each performed data access adds 2 to the offset after a word access and 1 after a byte access, modulo 2^OFF_W, so the offset stays within the page. When bit 14 is 0, the offset does not change.
- R5: A byte access works on the lane given by offset bit 0: bits [7:0] when it is 0, bits [15:8] when it is 1. rd_byte returns that lane. A byte write takes bus_wdata[7:0] and changes only that lane.
- R6: Data port select 3 is a second byte lane of the same data port. An access there is always a byte access, whatever bus_byte is.
- R7: Pointer bit 13 marks read intent. While it is 1, data writes do not change memory and do not advance the offset.
- R8: rd_valid is 0 in the cycle after any pointer write, packet-number write or performed data write. It is 1 again two clock edges after the event, and rd_word then shows the current address. It is also 0 whenever the word address differs from the address of the prefetched word.
- R9: A pointer write abandons any prefetch in flight. The next valid data comes from the newly loaded offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | 0 pointer, 1 packet number, 2 data port, 3 data byte lane |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Data read strobe, one cycle per access (advances the offset) |
| bus_byte | input | 1 | 1 selects byte access on data port select 2 |
| bus_wdata | input | 16 | Write data |
| rxq_head | input | PKT_W | Packet number at the head of the receive queue |
| rd_word | output | 16 | Prefetched word at the current word address |
| rd_byte | output | 8 | Byte lane of rd_word selected by offset bit 0 |
| rd_valid | output | 1 | Prefetched data matches the current address |

## Verification
Every word of every page is written with auto-incremented word writes, using a value computed from the packet and word index. The whole buffer is then read back with word reads, which shows whether page bases and offsets combine to distinct addresses. A full byte sweep of one page checks lane selection and the +1 step across word boundaries. Further directed patterns cover the receive-queue source, including a change of rxq_head, and the wrap at the page end. They also cover aligned access at odd offsets, single-lane writes through both data selects, writes ignored under read intent, the exact two-edge recovery of rd_valid, and a pointer reload one cycle after another.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  typedef enum logic [1:0] {
    SEL_PTR   = 2'd0,
    SEL_PNUM  = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_LANE2 = 2'd3
  } bus_sel_e;

  localparam int BIT_SRC_RX  = 15;
  localparam int BIT_AUTOINC = 14;
  localparam int BIT_RDINT   = 13;
  localparam int REFILL_CYC  = 2;
endpackage

// File: rtl/ppa_ptr_regs.sv
module ppa_ptr_regs #(
  parameter int PKT_W = 2,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_we,
  input  logic             pnum_we,
  input  logic [15:0]      wdata,
  input  logic             adv,
  input  logic             adv_byte,
  input  logic [PKT_W-1:0] rxq_head,
  output logic [OFF_W-1:0] off,
  output logic             auto_inc,
  output logic             rd_intent,
  output logic [PKT_W-1:0] pkt
);
  import ppa_pkg::*;

  logic             src_rx;
  logic [PKT_W-1:0] pnum;

  always_ff @(posedge clk) begin
    if (rst) begin
      off       <= '0;
      src_rx    <= 1'b0;
      auto_inc  <= 1'b0;
      rd_intent <= 1'b0;
    end else if (ptr_we) begin
      off       <= wdata[OFF_W-1:0];
      src_rx    <= wdata[BIT_SRC_RX];
      auto_inc  <= wdata[BIT_AUTOINC];
      rd_intent <= wdata[BIT_RDINT];
    end else if (adv && auto_inc) begin
      off <= off + (adv_byte ? OFF_W'(1) : OFF_W'(2));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pnum <= '0;
    else if (pnum_we) pnum <= wdata[PKT_W-1:0];
  end

  assign pkt = src_rx ? rxq_head : pnum;
endmodule

// File: rtl/ppa_ram.sv
module ppa_ram #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        we,
  input  logic [15:0]       wd,
  output logic [15:0]       q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wd[l*8 +: 8];
      q[l*8 +: 8] <= mem[addr];
    end
  end
endmodule

// File: rtl/ppa_rd_pipe.sv
module ppa_rd_pipe #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              restart,
  input  logic [15:0]       q,
  output logic [15:0]       rd_word,
  output logic              rd_valid
);
  import ppa_pkg::*;

  logic [ADDR_W-1:0] tag1, tag2;
  logic              v1, v2;
  logic [1:0]        hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag1    <= '0;
      tag2    <= '0;
      v1      <= 1'b0;
      v2      <= 1'b0;
      rd_word <= '0;
      hold    <= 2'(REFILL_CYC);
    end else begin
      tag1    <= addr;
      v1      <= 1'b1;
      tag2    <= tag1;
      v2      <= v1;
      rd_word <= q;
      if (restart)         hold <= 2'(REFILL_CYC);
      else if (hold != 0)  hold <= hold - 2'd1;
    end
  end

  assign rd_valid = v2 && (hold == 2'd0) && (tag2 == addr);
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port #(
  parameter int PKT_W = 2,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_byte,
  input  logic [15:0]      bus_wdata,
  input  logic [PKT_W-1:0] rxq_head,
  output logic [15:0]      rd_word,
  output logic [7:0]       rd_byte,
  output logic             rd_valid
);
  import ppa_pkg::*;

  localparam int ADDR_W = PKT_W + OFF_W - 1;

  logic             ptr_we, pnum_we, data_sel, is_byte, wr_ok, rd_acc, adv;
  logic [OFF_W-1:0] off;
  logic             auto_inc, rd_intent;
  logic [PKT_W-1:0] pkt;
  logic [ADDR_W-1:0] addr;
  logic [1:0]       ram_we;
  logic [15:0]      ram_wd, ram_q;

  assign ptr_we   = bus_wr && (bus_sel == SEL_PTR);
  assign pnum_we  = bus_wr && (bus_sel == SEL_PNUM);
  assign data_sel = (bus_sel == SEL_DATA) || (bus_sel == SEL_LANE2);
  assign is_byte  = (bus_sel == SEL_LANE2) || bus_byte;
  assign wr_ok    = bus_wr && data_sel && !rd_intent;
  assign rd_acc   = bus_rd && !bus_wr && data_sel;
  assign adv      = wr_ok || rd_acc;

  ppa_ptr_regs #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .pnum_we(pnum_we),
    .wdata(bus_wdata), .adv(adv), .adv_byte(is_byte), .rxq_head(rxq_head),
    .off(off), .auto_inc(auto_inc), .rd_intent(rd_intent), .pkt(pkt)
  );

  assign addr   = {pkt, off[OFF_W-1:1]};
  assign ram_we = !wr_ok ? 2'b00 : (!is_byte ? 2'b11 : (off[0] ? 2'b10 : 2'b01));
  assign ram_wd = is_byte ? {2{bus_wdata[7:0]}} : bus_wdata;

  ppa_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .addr(addr), .we(ram_we), .wd(ram_wd), .q(ram_q)
  );

  ppa_rd_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst(rst), .addr(addr), .restart(ptr_we || pnum_we || wr_ok),
    .q(ram_q), .rd_word(rd_word), .rd_valid(rd_valid)
  );

  assign rd_byte = off[0] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/ppa_chk.sv
module ppa_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_byte,
  input logic [15:0]      bus_wdata,
  input logic [OFF_W-1:0] off,
  input logic             auto_inc,
  input logic             rd_intent,
  input logic [1:0]       ram_we,
  input logic             rd_valid,
  input logic [15:0]      rd_word
);
  logic dsel, rd_word_acc, rd_byte_acc;
  assign dsel        = bus_sel[1];
  assign rd_word_acc = bus_rd && !bus_wr && (bus_sel == 2'd2) && !bus_byte;
  assign rd_byte_acc = bus_rd && !bus_wr && dsel && (bus_sel == 2'd3 || bus_byte);

  always_comb begin
    if (rst) a_reset_r1: assert (!rd_valid);
  end

  p_ptr_load_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd0) |=> (off == $past(bus_wdata[OFF_W-1:0])));

  p_word_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_word_acc && auto_inc) |=> (off == $past(off) + OFF_W'(2)));

  p_byte_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_byte_acc && auto_inc) |=> (off == $past(off) + OFF_W'(1)));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && dsel && !auto_inc) |=> $stable(off));

  p_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dsel && rd_intent) |-> (ram_we == 2'b00));

  p_stale_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (!dsel || !rd_intent)) |=> !rd_valid);
endmodule

bind pkt_ptr_port ppa_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_byte(bus_byte), .bus_wdata(bus_wdata), .off(off), .auto_inc(auto_inc),
  .rd_intent(rd_intent), .ram_we(ram_we), .rd_valid(rd_valid), .rd_word(rd_word)
);

// File: tb/pkt_ptr_port_tb.sv
module pkt_ptr_port_tb;
  localparam int PKT_W = 2;
  localparam int OFF_W = 8;
  localparam int WPP   = 1 << (OFF_W - 1);

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       bus_sel;
  logic             bus_wr, bus_rd, bus_byte;
  logic [15:0]      bus_wdata;
  logic [PKT_W-1:0] rxq_head;
  logic [15:0]      rd_word;
  logic [7:0]       rd_byte;
  logic             rd_valid;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pkt_ptr_port #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_byte(bus_byte), .bus_wdata(bus_wdata), .rxq_head(rxq_head),
    .rd_word(rd_word), .rd_byte(rd_byte), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] pat(int p, int w);
    return 16'((p * 16'h2711 + w * 16'h0133) ^ 16'hA55A);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(logic [1:0] sel, logic wr, logic rd, logic byt, logic [15:0] d);
    bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_byte = byt; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic wait_valid(string req);
    int n = 0;
    while (!rd_valid && n < 8) begin
      @(negedge clk);
      n++;
    end
    if (!rd_valid) check(req, 16'(rd_valid), 16'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_byte = 0;
    bus_wdata = 0; rxq_head = 0;
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", 16'(rd_valid), 16'h0);
    check("R1 rd_word in reset", rd_word, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4: fill every page with auto-incremented word writes
    for (int p = 0; p < (1 << PKT_W); p++) begin
      bus(2'd1, 1, 0, 0, 16'(p));
      bus(2'd0, 1, 0, 0, 16'h4000);
      for (int w = 0; w < WPP; w++) bus(2'd2, 1, 0, 0, pat(p, w));
    end

    // R3 R4: word readback of the whole buffer
    for (int p = 0; p < (1 << PKT_W); p++) begin
      bus(2'd1, 1, 0, 0, 16'(p));
      bus(2'd0, 1, 0, 0, 16'h6000);
      for (int w = 0; w < WPP; w++) begin
        wait_valid("R3 word sweep valid");
        check($sformatf("R3 word p%0d w%0d", p, w), rd_word, pat(p, w));
        bus(2'd2, 0, 1, 0, 16'h0);
      end
    end

    // R5 R4: byte sweep of page 1
    bus(2'd1, 1, 0, 0, 16'd1);
    bus(2'd0, 1, 0, 0, 16'h6000);
    for (int b = 0; b < (1 << OFF_W); b++) begin
      logic [15:0] wv;
      wv = pat(1, b >> 1);
      wait_valid("R5 byte sweep valid");
      check($sformatf("R5 byte %0d", b), 16'(rd_byte), 16'((b & 1) ? wv[15:8] : wv[7:0]));
      bus(2'd2, 0, 1, 1, 16'h0);
    end

    // R2: receive queue head as source
    bus(2'd1, 1, 0, 0, 16'd0);
    rxq_head = 2'd2;
    bus(2'd0, 1, 0, 0, 16'hE000 | 16'd10);
    wait_valid("R2 valid");
    check("R2 rx head 2", rd_word, pat(2, 5));
    rxq_head = 2'd3;
    @(negedge clk);
    check("R8 stale after rx head change", 16'(rd_valid), 16'h0);
    wait_valid("R2 valid");
    check("R2 rx head 3", rd_word, pat(3, 5));

    // R4: wrap at page end
    bus(2'd1, 1, 0, 0, 16'd1);
    bus(2'd0, 1, 0, 0, 16'h6000 | 16'd254);
    wait_valid("R4 valid");
    check("R4 last word", rd_word, pat(1, WPP - 1));
    bus(2'd2, 0, 1, 0, 16'h0);
    wait_valid("R4 valid");
    check("R4 wrap to word 0", rd_word, pat(1, 0));

    // R5 R6: single-lane writes through both selects
    bus(2'd1, 1, 0, 0, 16'd0);
    bus(2'd0, 1, 0, 0, 16'h4000 | 16'd7);
    bus(2'd2, 1, 0, 1, 16'hFF3C);
    bus(2'd3, 1, 0, 0, 16'hFF7E);
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd6);
    wait_valid("R5 valid");
    check("R5 high lane write", rd_word, {8'h3C, pat(0, 3)[7:0]});
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd8);
    wait_valid("R6 valid");
    check("R6 lane2 write", rd_word, {pat(0, 4)[15:8], 8'h7E});
    check("R6 rd_byte low lane", 16'(rd_byte), 16'h7E);

    // R4: no auto-increment
    bus(2'd2, 0, 1, 0, 16'h0);
    wait_valid("R4 valid");
    check("R4 offset held", rd_word, {pat(0, 4)[15:8], 8'h7E});

    // R7: write under read intent is ignored
    bus(2'd0, 1, 0, 0, 16'h6000 | 16'd20);
    bus(2'd2, 1, 0, 0, 16'hDEAD);
    wait_valid("R7 valid");
    check("R7 memory and offset unchanged", rd_word, pat(0, 10));

    // R3: odd offset word access is aligned
    bus(2'd1, 1, 0, 0, 16'd2);
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd5);
    wait_valid("R3 valid");
    check("R3 odd offset word", rd_word, pat(2, 2));

    // R8: exact refill latency after a pointer write
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd5);
    check("R8 low after edge 1", 16'(rd_valid), 16'h0);
    @(negedge clk);
    check("R8 low after edge 2", 16'(rd_valid), 16'h0);
    @(negedge clk);
    check("R8 high after edge 3", 16'(rd_valid), 16'h1);
    check("R8 data", rd_word, pat(2, 2));

    // R9: back-to-back pointer writes
    bus(2'd1, 1, 0, 0, 16'd3);
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd40);
    bus(2'd0, 1, 0, 0, 16'h2000 | 16'd60);
    wait_valid("R9 valid");
    check("R9 restart at new offset", rd_word, pat(3, 30));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule